// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Steering

This block sits between instruction alignment and the out-of-order machinery of a processor front end. Each clock it looks at a window of up to three aligned instructions and places them on three decode slots that are not alike. Slot 0 is the complex slot and can translate any instruction class. Slots 1 and 2 are simple slots and translate only single-micro-op instructions. Every micro-op it emits has the same fixed format: one opcode, two source register fields and one destination register field.

An instruction that expands to more micro-ops than the complex slot can produce is not decoded here. Its opcode goes out as an entry index to an external microcode sequencer. While that sequence runs, the block streams the sequencer's micro-ops onto the output lanes and does not decode. Program order always holds. When an instruction has to wait for the complex slot, every younger instruction in the window waits with it. The output is a valid/ready group of three lanes, and a stalled group stalls the whole decode.

The encoding is abstract. Each instruction states its class and its micro-op count. The micro-op opcodes are derived arithmetically, so the steering can be checked without a real opcode map.

Top module: `decode_steer`

## Requirements
- R1: At most three micro-ops leave per cycle. They always fill lanes from lane 0 upward, so `outLaneValid` is one of 3'b000, 3'b001, 3'b011 or 3'b111. `outValid` is high exactly when lane 0 is valid.
- R2: A micro-op is 20 bits wide: opcode [19:12], source A [11:8], source B [7:4], destination [3:0]. Lane i of `outUop` is bits [20i+19:20i]. Micro-op number j (counted from 0) of an instruction carries opcode = (instruction opcode + j) mod 256 and copies all three register fields of that instruction.
- R3: An instruction is 24 bits wide: class [23] (0 = simple, 1 = complex), count-minus-one [22:20], opcode [19:12], source A [11:8], source B [7:4], destination [3:0]. Window slot i of `inInst` is bits [24i+23:24i]. The oldest instruction always goes to the complex slot. A simple-class instruction yields exactly one micro-op, whatever its count field holds.
- R4: The complex slot translates a complex-class instruction of 1 to 4 micro-ops directly. If the instruction has more micro-ops than there are lanes, it is emitted over consecutive transfers: 3 micro-ops, then the remainder. During that first transfer `inTaken` is 0.
- R5: An instruction in window slot 1 or 2 is decoded in the same transfer only under four conditions: it is simple-class, the oldest instruction finishes in that transfer, the instructions ahead of it are also taken, and a lane is free. Otherwise it and all younger instructions are held. On an accepted transfer, `inTaken` counts the instructions consumed.
- R6: If the oldest instruction is complex-class with more than 4 micro-ops, the block raises `msStart` for one cycle with `msIndex` = its opcode. In that cycle `inTaken` = 1, `outValid` = 0, and the block enters sequencing.
- R7: While sequencing, the output lanes carry `msUop`/`msLaneValid` unchanged and `inTaken` is 0. `msAdvance` is high when the presented sequencer lanes are consumed, which means `outReady` is high or no lane is valid. Sequencing ends after a step in which `msLast` is high.
- R8: While `outValid` is high and `outReady` is low, `inTaken` is 0 and no decode state advances. The same group is presented again on the next cycle.
- R9: After reset the block is idle, with no sequence in progress and no partially emitted instruction. With no valid input, `outValid`, `inTaken` and `msStart` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 3 | Valid per window slot, contiguous from slot 0 |
| inInst | input | 72 | Three instructions, slot 0 is oldest |
| inTaken | output | 2 | Instructions consumed this cycle; upstream shifts the window by this |
| outValid | output | 1 | Micro-op group valid |
| outReady | input | 1 | Downstream accepts the group |
| outLaneValid | output | 3 | Valid per output lane |
| outUop | output | 60 | Three micro-ops |
| msStart | output | 1 | Starts a microcode sequence |
| msIndex | output | 8 | Sequence entry index (instruction opcode) |
| msLaneValid | input | 3 | Valid per sequencer lane |
| msUop | input | 60 | Sequencer micro-ops |
| msLast | input | 1 | Presented sequencer lanes end the sequence |
| msAdvance | output | 1 | Sequencer lanes consumed this cycle |

## Verification
The complex slot and the simple slots can both deliver in the same transfer. For example, a two-micro-op complex instruction is followed by a simple one, or a single-micro-op complex instruction is followed by two simple ones. Lane packing and the consumed count then depend on both. Random instruction mixes make such windows occur often, with count fields that vary within each class. Every cycle, a behavioural model in the bench, built on a queue, predicts the lane contents and the consumed count, and these are compared field by field. Random back-pressure is layered on top, so that these shared transfers and sequencer ends are also held across stall cycles.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int LANES    = 3;
  localparam int CPLX_MAX = 4;
  localparam int OPW      = 8;
  localparam int REGW     = 4;
  localparam int LENW     = 3;
  localparam int IDXW     = $clog2(CPLX_MAX);

  typedef struct packed {
    logic            cls;
    logic [LENW-1:0] lenM1;
    logic [OPW-1:0]  op;
    logic [REGW-1:0] srcA;
    logic [REGW-1:0] srcB;
    logic [REGW-1:0] dst;
  } inst_t;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [REGW-1:0] srcA;
    logic [REGW-1:0] srcB;
    logic [REGW-1:0] dst;
  } uop_t;

  localparam int INSTW = $bits(inst_t);
  localparam int UOPW  = $bits(uop_t);

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_I0   = 3'd1,
    SRC_I1   = 3'd2,
    SRC_I2   = 3'd3,
    SRC_SEQ  = 3'd4
  } lane_src_e;

  typedef struct packed {
    lane_src_e [LANES-1:0]            laneSrc;
    logic      [LANES-1:0][IDXW-1:0]  laneIdx;
  } strobe_t;
endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  inValid,
  input  logic              inst0Cls,
  input  logic [LENW-1:0]   inst0LenM1,
  input  logic              inst1Cls,
  input  logic              inst2Cls,
  input  logic              outReady,
  input  logic [LANES-1:0]  msLaneValid,
  input  logic              msLast,
  output strobe_t           strb,
  output logic              outValid,
  output logic [1:0]        inTaken,
  output logic              msStart,
  output logic              msAdvance
);
  logic            inSeq;
  logic [IDXW-1:0] doneCnt;
  logic [LENW:0]   len0, rem0, k0;
  logic            isMicro, decodeOk, fin0, take1, take2, fire, seqStep;

  always_comb begin
    len0     = (LENW+1)'(inst0LenM1) + (LENW+1)'(1);
    isMicro  = inValid[0] && inst0Cls && (int'(len0) > CPLX_MAX);
    decodeOk = !inSeq && inValid[0] && !isMicro;
    rem0     = inst0Cls ? len0 - (LENW+1)'(doneCnt) : (LENW+1)'(1);
    k0       = (int'(rem0) > LANES) ? (LENW+1)'(LANES) : rem0;
    fin0     = int'(rem0) <= LANES;
    take1    = fin0 && inValid[1] && !inst1Cls && (int'(k0) + 1 <= LANES);
    take2    = take1 && inValid[2] && !inst2Cls && (int'(k0) + 2 <= LANES);
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      strb.laneSrc[i] = SRC_NONE;
      strb.laneIdx[i] = '0;
      if (inSeq) begin
        if (msLaneValid[i]) strb.laneSrc[i] = SRC_SEQ;
      end else if (decodeOk) begin
        if (i < int'(k0)) begin
          strb.laneSrc[i] = SRC_I0;
          strb.laneIdx[i] = IDXW'(int'(doneCnt) + i);
        end else if (i == int'(k0) && take1) begin
          strb.laneSrc[i] = SRC_I1;
        end else if (i == int'(k0) + 1 && take2) begin
          strb.laneSrc[i] = SRC_I2;
        end
      end
    end
  end

  always_comb begin
    outValid  = inSeq ? (|msLaneValid) : decodeOk;
    fire      = outValid && outReady;
    msStart   = !inSeq && isMicro;
    seqStep   = inSeq && (outReady || msLaneValid == '0);
    msAdvance = seqStep;
    if (msStart)
      inTaken = 2'd1;
    else if (decodeOk && fire)
      inTaken = 2'(int'(fin0) + int'(take1) + int'(take2));
    else
      inTaken = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSeq   <= 1'b0;
      doneCnt <= '0;
    end else begin
      if (msStart)
        inSeq <= 1'b1;
      else if (seqStep && msLast)
        inSeq <= 1'b0;
      if (decodeOk && fire)
        doneCnt <= fin0 ? '0 : IDXW'(int'(doneCnt) + LANES);
    end
  end

  // R7
  seq_stalls_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    inSeq |-> (inTaken == 2'd0 && !msStart));

  // R6
  seq_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    msStart |=> (inSeq && inTaken == 2'd0));

  // R8
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> (inTaken == 2'd0));

  // R8
  stall_keeps_part_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !inSeq) |=> $stable(doneCnt));

  // R5
  taken_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(inTaken) <= $countones(inValid));
endmodule

// File: rtl/steer_dp.sv
module steer_dp
  import steer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  inst_t [LANES-1:0]   inst,
  input  uop_t  [LANES-1:0]   seqUop,
  output logic  [LANES-1:0]   laneValid,
  output uop_t  [LANES-1:0]   laneUop
);
  function automatic uop_t makeUop(inst_t src, logic [IDXW-1:0] idx);
    uop_t u;
    u.op   = src.op + OPW'(idx);
    u.srcA = src.srcA;
    u.srcB = src.srcB;
    u.dst  = src.dst;
    return u;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      laneValid[g] = strb.laneSrc[g] != SRC_NONE;
      unique case (strb.laneSrc[g])
        SRC_I0:  laneUop[g] = makeUop(inst[0], strb.laneIdx[g]);
        SRC_I1:  laneUop[g] = makeUop(inst[1], '0);
        SRC_I2:  laneUop[g] = makeUop(inst[2], '0);
        SRC_SEQ: laneUop[g] = seqUop[g];
        default: laneUop[g] = '0;
      endcase
    end
  end

  // R1
  lanes_packed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((laneValid & (laneValid + 1'b1)) == '0));
endmodule

// File: rtl/decode_steer.sv
module decode_steer
  import steer_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES-1:0]        inValid,
  input  logic [LANES*INSTW-1:0]  inInst,
  output logic [1:0]              inTaken,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [LANES-1:0]        outLaneValid,
  output logic [LANES*UOPW-1:0]   outUop,
  output logic                    msStart,
  output logic [OPW-1:0]          msIndex,
  input  logic [LANES-1:0]        msLaneValid,
  input  logic [LANES*UOPW-1:0]   msUop,
  input  logic                    msLast,
  output logic                    msAdvance
);
  inst_t [LANES-1:0] inst;
  uop_t  [LANES-1:0] seqUop, laneUop;
  strobe_t           strb;

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign inst[g]                    = inst_t'(inInst[g*INSTW +: INSTW]);
    assign seqUop[g]                  = uop_t'(msUop[g*UOPW +: UOPW]);
    assign outUop[g*UOPW +: UOPW]     = laneUop[g];
  end

  assign msIndex = inst[0].op;

  steer_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inst0Cls   (inst[0].cls),
    .inst0LenM1 (inst[0].lenM1),
    .inst1Cls   (inst[1].cls),
    .inst2Cls   (inst[2].cls),
    .outReady   (outReady),
    .msLaneValid(msLaneValid),
    .msLast     (msLast),
    .strb       (strb),
    .outValid   (outValid),
    .inTaken    (inTaken),
    .msStart    (msStart),
    .msAdvance  (msAdvance)
  );

  steer_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inst     (inst),
    .seqUop   (seqUop),
    .laneValid(outLaneValid),
    .laneUop  (laneUop)
  );
endmodule

// File: tb/test_decode_steer.sv
module test_decode_steer;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  inValid;
  logic [71:0] inInst;
  logic [1:0]  inTaken;
  logic        outValid, outReady;
  logic [2:0]  outLaneValid;
  logic [59:0] outUop;
  logic        msStart;
  logic [7:0]  msIndex;
  logic [2:0]  msLaneValid;
  logic [59:0] msUop;
  logic        msLast, msAdvance;

  always #10 clk = ~clk;

  decode_steer i_decode_steer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inInst(inInst), .inTaken(inTaken),
    .outValid(outValid), .outReady(outReady), .outLaneValid(outLaneValid), .outUop(outUop),
    .msStart(msStart), .msIndex(msIndex), .msLaneValid(msLaneValid), .msUop(msUop),
    .msLast(msLast), .msAdvance(msAdvance)
  );

  int vectors = 0;
  int fails = 0;
  bit [23:0] q[$];
  bit  mSeq = 0;
  int  mDone = 0;
  int  seqLeft = 0, seqPos = 0;
  bit [7:0] seqBase = 0;
  bit  randReady = 0;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit [23:0] mk(bit cls, int lenM1, int op, int a, int b, int d);
    return {cls, 3'(lenM1), 8'(op), 4'(a), 4'(b), 4'(d)};
  endfunction

  function automatic bit [19:0] uopOf(bit [23:0] ins, int j);
    return {8'(ins[19:12] + j), ins[11:0]};
  endfunction

  task automatic drive();
    inValid = '0; inInst = '0; msLaneValid = '0; msUop = '0; msLast = 1'b0;
    for (int i = 0; i < 3; i++)
      if (q.size() > i) begin
        inValid[i] = 1'b1;
        inInst[24*i +: 24] = q[i];
      end
    outReady = randReady ? ($urandom_range(0, 3) != 0) : 1'b1;
    if (mSeq) begin
      int n = (seqLeft < 3) ? seqLeft : 3;
      for (int i = 0; i < n; i++) begin
        msLaneValid[i] = 1'b1;
        msUop[20*i +: 20] = {8'(seqBase + seqPos + i), 4'(i), 4'(i + 1), 4'(seqPos + 5)};
      end
      msLast = seqLeft <= 3;
    end
  endtask

  task automatic evaluate();
    bit [2:0]  eLanes = '0;
    bit [59:0] eUop = '0;
    bit        eValid = 0, eStart = 0, eAdv = 0;
    int        eTaken = 0;
    string     tag = "R3";
    if (mSeq) begin
      tag = "R7";
      eLanes = msLaneValid;
      eUop = msUop;
      eValid = |msLaneValid;
      eAdv = outReady || msLaneValid == 0;
      if (eAdv) begin
        int n = (seqLeft < 3) ? seqLeft : 3;
        if (msLast) mSeq = 0;
        seqLeft -= n; seqPos += n;
      end
    end else if (q.size() > 0) begin
      bit [23:0] i0 = q[0];
      int len0 = int'(i0[22:20]) + 1;
      if (i0[23] && len0 > 4) begin
        tag = "R6";
        eStart = 1; eTaken = 1;
        check(tag, "msIndex", 64'(msIndex), 64'(i0[19:12]));
        void'(q.pop_front());
        mSeq = 1; seqLeft = len0; seqPos = 0; seqBase = i0[19:12] ^ 8'h5A;
      end else begin
        int rem = i0[23] ? len0 - mDone : 1;
        int k = (rem > 3) ? 3 : rem;
        bit fin = rem <= 3;
        int lane = 0;
        int nt = 0;
        if (i0[23]) tag = "R4";
        eValid = 1;
        for (int j = 0; j < k; j++) begin
          eLanes[lane] = 1; eUop[20*lane +: 20] = uopOf(i0, mDone + j); lane++;
        end
        if (fin) begin
          nt = 1;
          for (int s = 1; s < 3; s++) begin
            if (nt != s || q.size() <= s || q[s][23] || lane >= 3) break;
            eLanes[lane] = 1; eUop[20*lane +: 20] = uopOf(q[s], 0); lane++; nt++;
          end
        end
        if (!outReady) tag = "R8";
        else begin
          if (q.size() > 1) tag = "R5";
          eTaken = nt;
          for (int p = 0; p < nt; p++) void'(q.pop_front());
          mDone = fin ? 0 : mDone + 3;
        end
      end
    end
    check("R1", "outLaneValid", 64'(outLaneValid), 64'(eLanes));
    check("R1", "outValid", 64'(outValid), 64'(eValid));
    check("R2", "outUop", 64'(outUop & {{20{eLanes[2]}}, {20{eLanes[1]}}, {20{eLanes[0]}}}), 64'(eUop));
    check(tag, "inTaken", 64'(inTaken), 64'(eTaken));
    check(tag, "msStart", 64'(msStart), 64'(eStart));
    check("R7", "msAdvance", 64'(msAdvance), 64'(eAdv));
  endtask

  initial begin
    int cyc = 0;
    rstN = 1'b0; inValid = '0; inInst = '0; outReady = 1'b1;
    msLaneValid = '0; msUop = '0; msLast = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R9 idle after reset, nothing presented
    check("R9", "outValid", 64'(outValid), 64'd0);
    check("R9", "inTaken", 64'(inTaken), 64'd0);
    check("R9", "msStart", 64'(msStart), 64'd0);
    // directed groups: simple-class with non-zero count field (R3), complex mid-window (R5)
    q.push_back(mk(0, 5, 8'h10, 1, 2, 3));
    q.push_back(mk(0, 0, 8'h20, 4, 5, 6));
    q.push_back(mk(0, 7, 8'h30, 7, 8, 9));
    q.push_back(mk(1, 1, 8'h40, 1, 1, 1));
    q.push_back(mk(0, 0, 8'h50, 2, 2, 2));
    q.push_back(mk(0, 0, 8'h60, 3, 3, 3));
    q.push_back(mk(1, 3, 8'hFE, 4, 4, 4));
    q.push_back(mk(0, 0, 8'h70, 5, 5, 5));
    q.push_back(mk(1, 7, 8'h80, 6, 6, 6));
    q.push_back(mk(0, 0, 8'h90, 7, 7, 7));
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      int cls = (r < 5) ? 0 : 1;
      int lm = (r < 5) ? $urandom_range(0, 7) : (r < 9 ? $urandom_range(0, 3) : $urandom_range(4, 7));
      q.push_back(mk(1'(cls), lm, $urandom_range(0, 255), $urandom_range(0, 15),
                     $urandom_range(0, 15), $urandom_range(0, 15)));
    end
    while (cyc < 20000 && (q.size() > 0 || mSeq || mDone != 0)) begin
      @(posedge clk); #1;
      cyc++;
      if (cyc == 200) randReady = 1;
      drive();
      @(negedge clk);
      evaluate();
    end
    if (cyc >= 20000) begin
      fails++; vectors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule